// File: doc/BRIEF.md
# GPIO Interrupt Trigger and Status Unit

This unit watches a bank of asynchronous pad inputs and raises a sticky status flag for every pad whose programmed trigger condition occurs. Each pad has a three-bit trigger field: a level bit, a rising-polarity bit and a falling-polarity bit. With the level bit clear, the two polarity bits choose rising, falling or either-edge detection. With the level bit set, the same bits choose whether a high or a low level is the active state. Pad inputs pass through a two-flop synchroniser before any detection.

The status flags are packed 32 to a word in a small register window. Software reads a word to find the pending pads and writes ones to clear them. A single combined interrupt line is high whenever any flag is set. Each pad's flag is held by a two-state machine. The states are IDLE (flag clear) and PENDING (flag set). The transitions are IDLE to PENDING on a trigger event, PENDING to IDLE on a clear with no edge in the same cycle, and PENDING held on an edge or with no clear. A clear and an edge in the same cycle leave the pad PENDING. A clear outranks an active level for that one cycle, so the flag drops and then returns on the next cycle.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every status flag is 0, `irq_o` is 0, and reads of both status words return 0.
- R2: Pad p's trigger field is `trig_cfg_i[3p+2:3p]`, with bit 2 = falling, bit 1 = rising and bit 0 = level. A field with both polarity bits 0 never sets the pad's flag, at any pad activity.
- R3: With the level bit 0, field 3'b010 sets the flag on a rising pad edge, 3'b100 on a falling edge, and 3'b110 on either edge. An edge of the other direction does not set it.
- R4: With the level bit 1, field 3'b011 sets the flag while the pad is high and 3'b101 while the pad is low.
- R5: Pad p's flag reads at byte address 0x800 + 4*(p/32), bit p%32. Bits with no pad behind them, and any other address, read 0.
- R6: A write to a status word clears each flag whose data bit is 1 and leaves the flags whose data bit is 0. A write to any other address changes no flag.
- R7: When an edge event and a clearing write hit the same flag on the same clock edge, the flag stays set.
- R8: When a clear hits a flag whose level condition is still active, the flag reads 0 for exactly one cycle and then reads 1 again.
- R9: A set flag stays set after its condition goes away, until it is cleared.
- R10: `irq_o` is 1 exactly when at least one status flag is set.
- R11: An edge that arrives after a flag was cleared sets the flag again.
- R12: A pad change made just before clock edge 1 shows in the status on edge 3 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_i | input | NUM_PADS | Asynchronous pad levels |
| trig_cfg_i | input | 3*NUM_PADS | Per-pad trigger fields, 3 bits per pad |
| wr_en_i | input | 1 | Write strobe for the status window |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | 32 | Write data; ones clear flags |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | 32 | Read data for rd_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt, high while any flag is set |

## Verification
The bench aims at the cycle where a clear and a fresh edge collide. A design that lets the clear win there drops an edge and reads 0 where 1 is due. It also checks the level-active clear. That flag must show a single-cycle gap: a design that gives the clear no priority never dips, and one that masks the level stays at 0. Partial-mask and wrong-address writes catch a decoder that clears whole words or aliases addresses. Pads in the second word, and a two-versus-three edge latency probe, catch wrong packing and a missing or extra synchroniser stage.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W   = 32;
    localparam int TRIG_W   = 3;
    localparam int TB_LEVEL = 0;
    localparam int TB_RISE  = 1;
    localparam int TB_FALL  = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } pad_state_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

endmodule

// File: rtl/gpio_irq_pad.sv
module gpio_irq_pad
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_i,
    input  logic [TRIG_W-1:0] trig_i,
    input  logic              clr_i,
    output logic              pend_o
);

    pad_state_e state_q, state_d;
    logic       prev_q;
    logic       rise, fall, edge_evt, lvl_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise = lvl_i & ~prev_q;
    assign fall = ~lvl_i & prev_q;

    assign edge_evt = !trig_i[TB_LEVEL] &&
                      ((trig_i[TB_RISE] && rise) || (trig_i[TB_FALL] && fall));
    assign lvl_evt  = trig_i[TB_LEVEL] &&
                      ((trig_i[TB_RISE] && lvl_i) || (trig_i[TB_FALL] && !lvl_i));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: edge beats clear, clear beats level
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (edge_evt || lvl_evt) state_d = ST_PEND;
            ST_PEND: if (!edge_evt && clr_i)  state_d = ST_IDLE;
        endcase
    end

    // output process
    always_comb begin
        pend_o = (state_q == ST_PEND);
    end

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> pend_o);

    assert_off_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i[TB_RISE] == 1'b0 && trig_i[TB_FALL] == 1'b0 && !pend_o) |=> !pend_o);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && clr_i && !edge_evt) |=> !pend_o);

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int          NUM_PADS  = 40,
    parameter int          ADDR_W    = 12,
    parameter int unsigned STAT_BASE = 32'h800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [WORD_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    input  logic [NUM_PADS-1:0] status_i,
    output logic [NUM_PADS-1:0] clr_o,
    output logic [WORD_W-1:0]   rd_data_o
);

    localparam int NUM_WORDS = (NUM_PADS + WORD_W - 1) / WORD_W;
    localparam int PAD_SPAN  = NUM_WORDS * WORD_W;

    logic [NUM_WORDS-1:0] wr_hit;
    logic [NUM_WORDS-1:0] rd_hit;
    logic [PAD_SPAN-1:0]  status_ext;

    assign status_ext = PAD_SPAN'(status_i);

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        assign wr_hit[k] = wr_en_i && (wr_addr_i == ADDR_W'(STAT_BASE + 4 * k));
        assign rd_hit[k] = (rd_addr_i == ADDR_W'(STAT_BASE + 4 * k));
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_clr
        assign clr_o[p] = wr_hit[p / WORD_W] && wr_data_i[p % WORD_W];
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (rd_hit[k]) rd_data_o = rd_data_o | status_ext[k*WORD_W +: WORD_W];
        end
    end

    assert_one_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hit));

    assert_stray_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit == '0) |-> (clr_o == '0));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int          NUM_PADS  = 40,
    parameter int          ADDR_W    = 12,
    parameter int unsigned STAT_BASE = 32'h800
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PADS-1:0]        pad_i,
    input  logic [TRIG_W*NUM_PADS-1:0] trig_cfg_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [WORD_W-1:0]          wr_data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [WORD_W-1:0]          rd_data_o,
    output logic                       irq_o
);

    logic [NUM_PADS-1:0] pad_sync;
    logic [NUM_PADS-1:0] status;
    logic [NUM_PADS-1:0] clr;

    gpio_irq_sync #(.WIDTH(NUM_PADS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_i),
        .sync_o  (pad_sync)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        gpio_irq_pad u_pad (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (pad_sync[p]),
            .trig_i (trig_cfg_i[TRIG_W*p +: TRIG_W]),
            .clr_i  (clr[p]),
            .pend_o (status[p])
        );
    end

    gpio_irq_regs #(
        .NUM_PADS  (NUM_PADS),
        .ADDR_W    (ADDR_W),
        .STAT_BASE (STAT_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .status_i  (status),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    assign irq_o = |status;

    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_en_i) |=> irq_o);

endmodule

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;

    localparam int NP = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pad = '0;
    logic [3*NP-1:0] trig = '0;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [11:0]   rd_addr = 12'h800;
    logic [31:0]   rd_data;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_irq_unit #(.NUM_PADS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .pad_i(pad), .trig_cfg_i(trig),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    // trigger field {fall, rise, level}
    localparam logic [2:0] M_OFF = 3'b000, M_RISE = 3'b010, M_FALL = 3'b100,
                           M_BOTH = 3'b110, M_LHI = 3'b011, M_LLO = 3'b101,
                           M_LNONE = 3'b001;

    // vector: pad[13:6] mode[5:3] level_before[2] level_after[1] expected[0]
    localparam int NV = 14;
    localparam logic [13:0] VEC [NV] = '{
        {8'd3,  M_RISE,  1'b0, 1'b1, 1'b1},   // R3
        {8'd3,  M_RISE,  1'b1, 1'b0, 1'b0},   // R3
        {8'd7,  M_FALL,  1'b1, 1'b0, 1'b1},   // R3
        {8'd7,  M_FALL,  1'b0, 1'b1, 1'b0},   // R3
        {8'd33, M_BOTH,  1'b0, 1'b1, 1'b1},   // R3 R5
        {8'd33, M_BOTH,  1'b1, 1'b0, 1'b1},   // R3 R5
        {8'd39, M_OFF,   1'b0, 1'b1, 1'b0},   // R2
        {8'd39, M_OFF,   1'b1, 1'b0, 1'b0},   // R2
        {8'd25, M_LNONE, 1'b0, 1'b1, 1'b0},   // R2
        {8'd0,  M_LHI,   1'b0, 1'b1, 1'b1},   // R4
        {8'd0,  M_LHI,   1'b0, 1'b0, 1'b0},   // R4
        {8'd0,  M_LHI,   1'b1, 1'b0, 1'b1},   // R4 R9 sticky
        {8'd31, M_LLO,   1'b1, 1'b1, 1'b0},   // R4
        {8'd31, M_LLO,   1'b1, 1'b0, 1'b1}    // R4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cleanup();
        trig = '0;
        pad  = '0;
        idle(4);
        wr(12'h800, 32'hFFFF_FFFF);
        wr(12'h804, 32'hFFFF_FFFF);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(12'h800, d); chk("R1 word0", d, 32'h0);
        rd(12'h804, d); chk("R1 word1", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            int          p;
            logic [2:0]  m;
            logic [31:0] exp;
            p = int'(VEC[v][13:6]);
            m = VEC[v][5:3];
            trig[3*p +: 3] = m;
            pad[p] = VEC[v][2];
            idle(6);
            wr(12'h800, 32'hFFFF_FFFF);
            wr(12'h804, 32'hFFFF_FFFF);
            pad[p] = VEC[v][1];
            idle(5);
            exp = VEC[v][0] ? (32'h1 << (p % 32)) : 32'h0;
            rd(p < 32 ? 12'h800 : 12'h804, d);
            chk($sformatf("R2/R3/R4/R5 vector %0d", v), d, exp);
            chk($sformatf("R10 vector %0d irq", v), {31'b0, irq}, {31'b0, VEC[v][0]});
            cleanup();
        end

        // R12 latency: pad change before edge 1, status on edge 3
        trig[3*5 +: 3] = M_RISE;
        idle(1);
        pad[5] = 1'b1;
        @(negedge clk); rd(12'h800, d); chk("R12 after edge1", d, 32'h0);
        @(negedge clk); rd(12'h800, d); chk("R12 after edge2", d, 32'h0);
        @(negedge clk); rd(12'h800, d); chk("R12 after edge3", d, 32'h20);
        cleanup();

        // R6 partial clear and stray writes
        trig[3*3 +: 3] = M_RISE;
        trig[3*7 +: 3] = M_RISE;
        pad[3] = 1'b1; pad[7] = 1'b1;
        idle(5);
        rd(12'h800, d); chk("R6 setup", d, 32'h88);
        wr(12'h800, 32'h8);
        rd(12'h800, d); chk("R6 one clears", d, 32'h80);
        wr(12'h800, 32'h0);
        rd(12'h800, d); chk("R6 zero keeps", d, 32'h80);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h800, d); chk("R6 other address", d, 32'h80);
        wr(12'h804, 32'hFFFF_FFFF);
        rd(12'h800, d); chk("R6 other word", d, 32'h80);
        rd(12'h808, d); chk("R5 unmapped read", d, 32'h0);
        cleanup();

        // R7 edge and clear on the same edge
        trig[3*10 +: 3] = M_BOTH;
        pad[10] = 1'b1;
        idle(4);
        rd(12'h800, d); chk("R3 both rising", d, 32'h400);
        @(negedge clk); pad[10] = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; wr_addr = 12'h800; wr_data = 32'h400;
        @(negedge clk); wr_en = 1'b0;
        rd(12'h800, d); chk("R7 set wins", d, 32'h400);
        wr(12'h800, 32'h400);
        rd(12'h800, d); chk("R6 clear without edge", d, 32'h0);
        cleanup();

        // R8 level-active clear dips for one cycle
        trig[3*12 +: 3] = M_LHI;
        pad[12] = 1'b1;
        idle(4);
        @(negedge clk); wr_en = 1'b1; wr_addr = 12'h800; wr_data = 32'h1000;
        @(negedge clk); wr_en = 1'b0;
        rd(12'h800, d); chk("R8 dip", d, 32'h0);
        chk("R10 irq dip", {31'b0, irq}, 32'h0);
        @(negedge clk);
        rd(12'h800, d); chk("R8 reassert", d, 32'h1000);
        chk("R10 irq back", {31'b0, irq}, 32'h1);
        cleanup();

        // R11 edge after clear
        trig[3*20 +: 3] = M_RISE;
        pad[20] = 1'b1;
        idle(4);
        wr(12'h800, 32'h0010_0000);
        rd(12'h800, d); chk("R11 cleared", d, 32'h0);
        pad[20] = 1'b0; idle(3);
        pad[20] = 1'b1; idle(4);
        rd(12'h800, d); chk("R11 new edge", d, 32'h0010_0000);
        cleanup();

        // R10 second word drives irq
        pad[38] = 1'b1;
        idle(4);
        trig[3*38 +: 3] = M_FALL;
        idle(2);
        pad[38] = 1'b0;
        idle(4);
        rd(12'h804, d); chk("R5 word1 bit6", d, 32'h40);
        rd(12'h800, d); chk("R5 word0 clean", d, 32'h0);
        chk("R10 irq set", {31'b0, irq}, 32'h1);
        wr(12'h804, 32'h40);
        chk("R10 irq cleared", {31'b0, irq}, 32'h0);

        summary();
        $finish;
    end

endmodule